// File: doc/BRIEF.md
# Counter-Based Hardware Loop Sequencer

This block steers instruction fetch for a three-stage pipeline (fetch, decode, execute) through counted loops at no cycle cost. A loop command is flagged in the cycle its own instruction is fetched, together with the address of the last body instruction. The block pushes the address of the first body instruction onto a return stack, and the end address, a pass number and the iteration count onto a loop stack. Whenever fetch reaches the end address of the innermost active loop, the next fetch address comes from the return stack until the count is used up.

The iteration count is read only when the loop command reaches execute, two cycles after its fetch. A body that ends early in that window is therefore fetched again before the count is known. Copies of a pass beyond the count are marked killed and travel down the pipeline as no-ops. The block flags these squashed cycles so that interrupt entry can be held off. A break input leaves the innermost loop at once. Sticky flags report pushes onto a full stack and pops from an empty one.

Top module: `hwloop_seq`

## Requirements
- R1: Synchronous active-high reset sets the fetch address to BOOT_PC (0), empties both stacks, marks the decode and execute slots invalid, and clears every kill flag, the interrupt hold and both error flags.
- R2: When the fetch address is not the end address of the innermost loop and no break is applied, the next fetch address is the current one plus 1.
- R3: A loop command in the fetch slot pushes (command address + 1) as the loop top and the given end address. The count on `loop_cnt_i` is sampled in the cycle the command occupies the execute slot and is usable from the next cycle on. A count of 0 runs like a count of 1.
- R4: At the end address, fetch returns to the loop top if the count is not yet usable, or if the pass being fetched is lower than the count. Each return starts the next pass.
- R5: At the end address, once the count is usable and the current pass is at least the count, both stacks pop and fetch continues at end + 1.
- R6: Every fetched body slot whose pass number exceeds the count is killed. Body length L and count C give max(C, ceil(3/L)) fetched passes. For example, L=2 with C=1 kills two slots, L=1 with C=2 kills one slot, and L=2 with C=2 or L=1 with C=3 kills none.
- R7: A slot killed in decode reaches execute one cycle later, still valid and still killed. A killed execute slot is always valid.
- R8: `irq_hold_o` is high in exactly those cycles in which the decode slot or the execute slot is killed.
- R9: Loops nest. Only the innermost loop's end address is compared. After it exits, the enclosing loop's end address, count and pass take effect in the very next fetch cycle.
- R10: The stacks hold DEPTH (6) loops. A loop command that arrives while they are full is not pushed and sets `ovf_o`, which stays high until reset.
- R11: `loop_break_i` pops the innermost loop, and the next fetch address is the current one plus 1. A break with no active loop sets `unf_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_cmd_i | input | 1 | The instruction in the fetch slot is a loop command |
| loop_end_i | input | AW | Address of the last body instruction, valid with `loop_cmd_i` |
| loop_cnt_i | input | CW | Iteration count, sampled while the command is in execute |
| loop_break_i | input | 1 | Leave the innermost loop |
| fetch_pc_o | output | AW | Address fetched in this cycle |
| fch_kill_o | output | 1 | The slot fetched now is already known to be squashed |
| dec_valid_o | output | 1 | The decode slot holds an instruction |
| dec_pc_o | output | AW | Address in the decode slot |
| dec_kill_o | output | 1 | The decode slot is squashed |
| exe_valid_o | output | 1 | The execute slot holds an instruction |
| exe_pc_o | output | AW | Address in the execute slot |
| exe_kill_o | output | 1 | The execute slot is squashed and has no effect |
| irq_hold_o | output | 1 | Defer interrupt entry for this cycle |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The assertions check on every cycle the properties that hold whatever the program does. These are the stack-depth bound, the stickiness of both error flags, a full push or empty pop leaving the depth unchanged, a killed decode slot reaching execute still killed, fetch only ever stepping forward by one or jumping back, and a break stepping forward by one. Only the bench's scenarios can show the exact pass sequences and which copies are squashed for each pairing of body length and count. The bench also shows that the stacks hold exactly six loops and that an enclosing loop resumes with no lost cycle.

// File: rtl/hwloop_seq.sv
`timescale 1ns/1ps
module hwloop_seq #(
  parameter int AW      = 16,
  parameter int CW      = 8,
  parameter int DEPTH   = 6,
  parameter int BOOT_PC = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loop_cmd_i,
  input  logic [AW-1:0] loop_end_i,
  input  logic [CW-1:0] loop_cnt_i,
  input  logic          loop_break_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic          fch_kill_o,
  output logic          dec_valid_o,
  output logic [AW-1:0] dec_pc_o,
  output logic          dec_kill_o,
  output logic          exe_valid_o,
  output logic [AW-1:0] exe_pc_o,
  output logic          exe_kill_o,
  output logic          irq_hold_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] top_q   [DEPTH];
  logic [AW-1:0] end_q   [DEPTH];
  logic [CW-1:0] cnt_q   [DEPTH];
  logic [CW-1:0] pass_q  [DEPTH];
  logic          known_q [DEPTH];
  logic [SPW-1:0] sp_q;

  logic [AW-1:0] pc_q, pc_nxt;
  logic          ovf_q, unf_q;

  logic          d_valid, d_kill, d_cmd;
  logic [AW-1:0] d_pc;
  logic [IW-1:0] d_idx, d_lvl;
  logic [CW-1:0] d_pass;
  logic          e_valid, e_kill, e_cmd;
  logic [AW-1:0] e_pc;
  logic [IW-1:0] e_idx;
  logic          jl_q;
  logic [IW-1:0] jl_idx_q;

  logic          has_top, full, at_end, in_body, expire, loop_back, push, load, late_kill;
  logic [IW-1:0] tix;
  logic [CW-1:0] cnt_fix;

  assign has_top   = (sp_q != '0);
  assign full      = (sp_q == SPW'(DEPTH));
  assign tix       = has_top ? IW'(sp_q - 1'b1) : '0;
  assign at_end    = has_top && (pc_q == end_q[tix]);
  assign in_body   = has_top && (pc_q >= top_q[tix]) && (pc_q <= end_q[tix]);
  assign expire    = at_end && known_q[tix] && (pass_q[tix] >= cnt_q[tix]);
  assign loop_back = at_end && !expire;
  assign push      = loop_cmd_i && !loop_break_i && !full;
  assign load      = e_valid && e_cmd && !e_kill && (SPW'(e_idx) < sp_q);
  assign cnt_fix   = (loop_cnt_i == '0) ? CW'(1) : loop_cnt_i;
  assign pc_nxt    = (loop_back && !loop_break_i) ? top_q[tix] : pc_q + AW'(1);

  assign late_kill = jl_q && d_valid && (d_lvl == jl_idx_q) && (d_pass > cnt_q[jl_idx_q]);

  assign fetch_pc_o  = pc_q;
  assign fch_kill_o  = in_body && known_q[tix] && (pass_q[tix] > cnt_q[tix]);
  assign dec_valid_o = d_valid;
  assign dec_pc_o    = d_pc;
  assign dec_kill_o  = d_kill | late_kill;
  assign exe_valid_o = e_valid;
  assign exe_pc_o    = e_pc;
  assign exe_kill_o  = e_kill;
  assign irq_hold_o  = dec_kill_o | e_kill;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= AW'(BOOT_PC);
      sp_q    <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      d_valid <= 1'b0;
      d_kill  <= 1'b0;
      d_cmd   <= 1'b0;
      e_valid <= 1'b0;
      e_kill  <= 1'b0;
      e_cmd   <= 1'b0;
      jl_q    <= 1'b0;
    end else begin
      pc_q <= pc_nxt;
      if (loop_break_i) begin
        if (has_top) sp_q <= sp_q - 1'b1;
        else         unf_q <= 1'b1;
      end else if (expire) begin
        sp_q <= sp_q - 1'b1;
      end else begin
        if (loop_back) pass_q[tix] <= pass_q[tix] + CW'(1);
        if (loop_cmd_i) begin
          if (full) ovf_q <= 1'b1;
          else begin
            top_q[IW'(sp_q)]   <= pc_q + AW'(1);
            end_q[IW'(sp_q)]   <= loop_end_i;
            pass_q[IW'(sp_q)]  <= CW'(1);
            known_q[IW'(sp_q)] <= 1'b0;
            sp_q               <= sp_q + 1'b1;
          end
        end
      end
      if (load) begin
        cnt_q[e_idx]   <= cnt_fix;
        known_q[e_idx] <= 1'b1;
      end
      jl_q     <= load;
      jl_idx_q <= e_idx;

      d_valid <= 1'b1;
      d_pc    <= pc_q;
      d_kill  <= fch_kill_o;
      d_cmd   <= push;
      d_idx   <= IW'(sp_q);
      d_lvl   <= tix;
      d_pass  <= in_body ? pass_q[tix] : '0;

      e_valid <= d_valid;
      e_pc    <= d_pc;
      e_kill  <= dec_kill_o;
      e_cmd   <= d_cmd;
      e_idx   <= d_idx;
    end
  end
endmodule

// File: rtl/hwloop_seq_chk.sv
`timescale 1ns/1ps
module hwloop_seq_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 6
) (
  input logic                         clk,
  input logic                         rst,
  input logic [$clog2(DEPTH+1)-1:0]   sp,
  input logic [AW-1:0]                fetch_pc,
  input logic                         cmd,
  input logic                         brk,
  input logic                         ovf,
  input logic                         unf,
  input logic                         dec_valid,
  input logic                         dec_kill,
  input logic                         exe_valid,
  input logic                         exe_kill
);
  localparam int SPW = $clog2(DEPTH + 1);

  p_sp_bound_r10: assert property (@(posedge clk) disable iff (rst) sp <= SPW'(DEPTH));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  p_full_push_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd && !brk && sp == SPW'(DEPTH)) |=> (ovf && sp == SPW'(DEPTH)));
  p_unf_sticky_r11: assert property (@(posedge clk) disable iff (rst) unf |=> unf);
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (brk && sp == '0) |=> (unf && sp == '0));
  p_brk_step_r11: assert property (@(posedge clk) disable iff (rst)
    brk |=> (fetch_pc == $past(fetch_pc) + AW'(1)));
  p_kill_flow_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kill) |=> (exe_valid && exe_kill));
  p_kill_valid_r7: assert property (@(posedge clk) disable iff (rst) exe_kill |-> exe_valid);
  p_redirect_r4: assert property (@(posedge clk) disable iff (rst)
    !brk |=> ((fetch_pc == $past(fetch_pc) + AW'(1)) || (fetch_pc <= $past(fetch_pc))));
endmodule

bind hwloop_seq hwloop_seq_chk #(.AW(AW), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .sp(sp_q), .fetch_pc(fetch_pc_o), .cmd(loop_cmd_i),
  .brk(loop_break_i), .ovf(ovf_o), .unf(unf_o), .dec_valid(dec_valid_o),
  .dec_kill(dec_kill_o), .exe_valid(exe_valid_o), .exe_kill(exe_kill_o)
);

// File: tb/test_hwloop_seq.sv
`timescale 1ns/1ps
module test_hwloop_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loop_cmd_i = 1'b0;
  logic [15:0] loop_end_i = '0;
  logic [7:0]  loop_cnt_i = '0;
  logic        loop_break_i = 1'b0;
  logic [15:0] fetch_pc_o, dec_pc_o, exe_pc_o;
  logic        fch_kill_o, dec_valid_o, dec_kill_o, exe_valid_o, exe_kill_o;
  logic        irq_hold_o, ovf_o, unf_o;

  int errors = 0;
  int checks = 0;
  int exp_pc [64];
  bit exp_k  [64];
  int sw_l, sw_c;

  always #5 clk = ~clk;

  hwloop_seq i_hwloop_seq (
    .clk(clk), .rst(rst), .loop_cmd_i(loop_cmd_i), .loop_end_i(loop_end_i),
    .loop_cnt_i(loop_cnt_i), .loop_break_i(loop_break_i), .fetch_pc_o(fetch_pc_o),
    .fch_kill_o(fch_kill_o), .dec_valid_o(dec_valid_o), .dec_pc_o(dec_pc_o),
    .dec_kill_o(dec_kill_o), .exe_valid_o(exe_valid_o), .exe_pc_o(exe_pc_o),
    .exe_kill_o(exe_kill_o), .irq_hold_o(irq_hold_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // R1: reset state
  task automatic do_reset();
    rst = 1'b1; loop_cmd_i = 1'b0; loop_break_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 fetch_pc", 32'(fetch_pc_o), 0);
    chk("R1 dec_valid", 32'(dec_valid_o), 0);
    chk("R1 exe_valid", 32'(exe_valid_o), 0);
    chk("R1 kills", 32'({fch_kill_o, dec_kill_o, exe_kill_o}), 0);
    chk("R1 hold", 32'(irq_hold_o), 0);
    chk("R1 flags", 32'({ovf_o, unf_o}), 0);
  endtask

  task automatic build_sweep(int l, int c);
    int cf, spec, np, n;
    cf = (c == 0) ? 1 : c;
    spec = (3 + l - 1) / l;
    np = (cf > spec) ? cf : spec;
    n = 0;
    for (int i = 0; i < 3; i++) begin exp_pc[n] = i; exp_k[n] = 0; n++; end
    for (int p = 1; p <= np; p++)
      for (int j = 0; j < l; j++) begin
        exp_pc[n] = 3 + j; exp_k[n] = (p > cf); n++;
      end
    for (int a = 3 + l; n < 64; a++) begin exp_pc[n] = a; exp_k[n] = 0; n++; end
  endtask

  task automatic build_nested();
    int seq [17] = '{0, 1, 2, 3, 4, 4, 4, 5, 6, 7, 3, 4, 4, 4, 5, 6, 7};
    for (int i = 0; i < 64; i++) begin
      exp_pc[i] = (i < 17) ? seq[i] : i - 9;
      exp_k[i]  = (i == 5) || (i == 6) || (i == 12) || (i == 13);
    end
  endtask

  task automatic build_straight();
    for (int i = 0; i < 64; i++) begin exp_pc[i] = i; exp_k[i] = 0; end
  endtask

  task automatic run(int ncyc, int mode, string pfx);
    for (int c = 0; c < ncyc; c++) begin
      bit hexp;
      if (c >= 2) begin
        chk({pfx, " exe_pc"}, 32'(exe_pc_o), 32'(exp_pc[c-2]));
        chk("R6 R7 exe_kill", 32'(exe_kill_o), 32'(exp_k[c-2]));
      end
      if (c >= 1) begin
        chk("R6 dec_kill", 32'(dec_kill_o), 32'(exp_k[c-1]));
        chk({pfx, " dec_pc"}, 32'(dec_pc_o), 32'(exp_pc[c-1]));
      end
      hexp = ((c >= 1) ? exp_k[c-1] : 1'b0) | ((c >= 2) ? exp_k[c-2] : 1'b0);
      chk("R8 irq_hold", 32'(irq_hold_o), 32'(hexp));
      case (mode)
        0: begin
          loop_cmd_i   = (fetch_pc_o == 16'd2);
          loop_end_i   = 16'(2 + sw_l);
          loop_cnt_i   = 8'(sw_c);
          loop_break_i = 1'b0;
        end
        1: begin
          loop_cmd_i   = (fetch_pc_o == 16'd2) || (fetch_pc_o == 16'd3);
          loop_end_i   = (fetch_pc_o == 16'd2) ? 16'd7 : 16'd4;
          loop_cnt_i   = (exe_pc_o == 16'd2) ? 8'd2 : 8'd1;
          loop_break_i = 1'b0;
        end
        default: begin
          chk("R2 R11 fetch_pc", 32'(fetch_pc_o), 32'(c));
          if (fetch_pc_o == 16'd8)  chk("R10 ovf before", 32'(ovf_o), 0);
          if (fetch_pc_o == 16'd9)  chk("R10 ovf after", 32'(ovf_o), 1);
          if (fetch_pc_o == 16'd18) chk("R11 unf before", 32'(unf_o), 0);
          if (fetch_pc_o == 16'd19) begin
            chk("R11 unf after", 32'(unf_o), 1);
            chk("R10 ovf sticky", 32'(ovf_o), 1);
          end
          loop_cmd_i   = (fetch_pc_o >= 16'd2) && (fetch_pc_o <= 16'd8);
          loop_end_i   = 16'd60 - (fetch_pc_o - 16'd2);
          loop_cnt_i   = 8'd5;
          loop_break_i = (fetch_pc_o >= 16'd12) && (fetch_pc_o <= 16'd18);
        end
      endcase
      @(negedge clk);
    end
    loop_cmd_i = 1'b0; loop_break_i = 1'b0;
  endtask

  initial begin
    // R3 R4 R5 R6: every body length 1..4 with every count 0..5
    for (int l = 1; l <= 4; l++)
      for (int c = 0; c <= 5; c++) begin
        sw_l = l; sw_c = c;
        build_sweep(l, c);
        do_reset();
        run(40, 0, "R3 R4 R5 R6");
      end
    // R9: nested loops, inner one squashed, outer resumes at once
    build_nested();
    do_reset();
    run(30, 1, "R9");
    // R10 R11: seven pushes onto a six-deep stack, then seven breaks
    build_straight();
    do_reset();
    run(30, 2, "R10 R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule